// File: doc/BRIEF.md
# MDIO Management Frame Master

This block is the station-management master for an Ethernet PHY. Software places one complete 32-bit management word on a write port. The word holds the start pattern, the operation code, the PHY and register addresses, the turnaround pattern and sixteen data bits. The block then sends a 32-bit run of ones on MDIO, followed by the word itself, most significant bit first. All of this is timed by an MDC clock that the block derives from the system clock.

On a read, the master stops driving MDIO from the turnaround onward. It samples the sixteen data bits that the PHY returns and places them in the low half of the same word, which software reads back once the block is idle again. The divide ratio for MDC is picked from a short menu of values. A port enable gates the whole block: while the enable is low, no frame can start, and a frame already running is cut short.

Top module: `mdio_frame_master`

## Requirements
- R1: After reset, idle is 1, mdc is 0, mdio_oe is 0, mdio_o is 0 and frame_rdata is 0.
- R2: A frame_wr pulse sampled while idle is 1 and port_en is 1 loads frame_wdata into frame_rdata and starts a frame. From the next cycle, idle is 0, mdc is 0, and MDIO is driven high.
- R3: One MDC period takes N system clocks: mdc is low for the first N/2 and high for the last N/2. N is chosen by div_sel: 0 gives 8, 1 gives 16, 2 gives 32, 3 gives 48, 4 gives 64, and 5, 6 and 7 give 96.
- R4: div_sel is taken at the accepting edge. A later change to div_sel has no effect until the next frame.
- R5: During MDC periods 0 to 31 of a frame, mdio_oe is 1 and mdio_o is 1 (preamble).
- R6: During period 32+k (k = 0..31), mdio_o carries bit 31-k of the word. Each new bit appears in the cycle where mdc falls. The field layout is [31:30] start 01, [29:28] operation (01 write, 10 read), [27:23] PHY address, [22:18] register address, [17:16] turnaround 10, [15:0] data. After 64·N cycles, idle returns to 1, mdc is 0 and mdio_oe is 0. For any operation code other than 10, MDIO is driven for the whole frame, and frame_rdata at the end equals the loaded word.
- R7: For a read (bits [29:28] = 10), mdio_oe is 0 from period 46 (the first turnaround bit) through period 63.
- R8: On a read, mdio_i is sampled at each rising MDC edge of periods 48 to 63, giving data bits 15 down to 0. At the end, frame_rdata equals {word[31:16], sampled data}.
- R9: frame_wr while idle is 0 is ignored. This includes a write in the cycle where the frame completes: the block stays idle after that frame and keeps its result.
- R10: frame_wr while port_en is 0 is ignored: idle stays 1, mdc stays low and frame_rdata is unchanged.
- R11: If port_en falls during a frame, then in the next cycle idle is 1, mdc is 0 and mdio_oe is 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| port_en | input | 1 | Management port enable |
| div_sel | input | 3 | MDC divide-ratio select |
| frame_wr | input | 1 | Write strobe for the management word |
| frame_wdata | input | 32 | Management word to send |
| frame_rdata | output | 32 | Current word; holds read data once idle |
| idle | output | 1 | High when no frame is in progress |
| mdc | output | 1 | Management clock to the PHY |
| mdio_o | output | 1 | MDIO output value |
| mdio_oe | output | 1 | MDIO output enable (0 releases the line) |
| mdio_i | input | 1 | MDIO input value |

## Verification
Two events can fall in the same cycle: frame completion and a new write request. The bench raises frame_wr so that it is sampled on the very edge at which the last MDC period ends. The design must then stay idle, keep the completed word in frame_rdata, and not start a second frame. A write arriving in the middle of a frame is also checked against the cycle-exact MDC and MDIO timeline, and so is a change of div_sel during a frame. That timeline is computed independently on every clock.

// File: rtl/mdio_pkg.sv
package mdio_pkg;

  localparam int HALF_W = 6;
  localparam int OP_HI  = 29;
  localparam int OP_LO  = 28;
  localparam logic [1:0] OP_READ = 2'b10;

  // Half MDC period in system clocks for each select code.
  function automatic logic [HALF_W-1:0] half_period(input logic [2:0] sel);
    case (sel)
      3'd0:    half_period = 6'd4;
      3'd1:    half_period = 6'd8;
      3'd2:    half_period = 6'd16;
      3'd3:    half_period = 6'd24;
      3'd4:    half_period = 6'd32;
      default: half_period = 6'd48;
    endcase
  endfunction

endpackage

// File: rtl/mdio_mdc_gen.sv
module mdio_mdc_gen #(
  parameter int HALF_W = 6
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              start,
  input  logic              run,
  input  logic [HALF_W-1:0] half_in,
  output logic              mdc,
  output logic              rise,
  output logic              fall
);
  logic [HALF_W-1:0] half_q;
  logic [HALF_W-1:0] cnt_q;
  logic              tick;

  assign tick = run && (cnt_q == half_q - 1'b1);
  assign rise = tick && !mdc;
  assign fall = tick && mdc;

  always_ff @(posedge clk) begin
    if (rst) begin
      half_q <= '1;
      cnt_q  <= '0;
      mdc    <= 1'b0;
    end else if (start) begin
      half_q <= half_in;
      cnt_q  <= '0;
      mdc    <= 1'b0;
    end else if (!run) begin
      cnt_q  <= '0;
      mdc    <= 1'b0;
    end else if (tick) begin
      cnt_q  <= '0;
      mdc    <= ~mdc;
    end else begin
      cnt_q  <= cnt_q + 1'b1;
    end
  end
endmodule

// File: rtl/mdio_bit_seq.sv
module mdio_bit_seq #(
  parameter int TOTAL = 64,
  parameter int CNT_W = $clog2(TOTAL)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             start,
  input  logic             abort,
  input  logic             fall,
  output logic             busy,
  output logic [CNT_W-1:0] bit_idx
);
  localparam logic [CNT_W-1:0] LAST = CNT_W'(TOTAL - 1);

  always_ff @(posedge clk) begin
    if (rst) begin
      busy    <= 1'b0;
      bit_idx <= '0;
    end else if (start) begin
      busy    <= 1'b1;
      bit_idx <= '0;
    end else if (abort) begin
      busy    <= 1'b0;
      bit_idx <= '0;
    end else if (fall) begin
      if (bit_idx == LAST) begin
        busy    <= 1'b0;
        bit_idx <= '0;
      end else begin
        bit_idx <= bit_idx + 1'b1;
      end
    end
  end
endmodule

// File: rtl/mdio_shift_unit.sv
module mdio_shift_unit
  import mdio_pkg::*;
#(
  parameter int FRAME_W = 32,
  parameter int DATA_W  = 16,
  parameter int PRE_LEN = 32,
  parameter int TA_OFS  = 14,
  parameter int CNT_W   = 6
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               start,
  input  logic               abort,
  input  logic               rise,
  input  logic               fall,
  input  logic [CNT_W-1:0]   bit_idx,
  input  logic [FRAME_W-1:0] load_word,
  input  logic               mdio_i,
  output logic [FRAME_W-1:0] frame_q,
  output logic               mdio_o,
  output logic               mdio_oe
);
  localparam logic [CNT_W-1:0] FIRST_FRM = CNT_W'(PRE_LEN);
  localparam logic [CNT_W-1:0] TA_FROM   = CNT_W'(PRE_LEN + TA_OFS);
  localparam logic [CNT_W-1:0] RX_FROM   = CNT_W'(PRE_LEN + FRAME_W - DATA_W);
  localparam logic [CNT_W-1:0] LAST      = CNT_W'(PRE_LEN + FRAME_W - 1);

  logic             is_rd_q;
  logic             rx_q;
  logic [CNT_W-1:0] nxt_idx;
  logic             in_rx;
  logic             shift_in;

  assign nxt_idx  = bit_idx + 1'b1;
  assign in_rx    = is_rd_q && (bit_idx >= RX_FROM);
  // Rotate header bits back in; on a read, replace data bits with samples.
  assign shift_in = in_rx ? rx_q : frame_q[FRAME_W-1];

  always_ff @(posedge clk) begin
    if (rst) begin
      frame_q <= '0;
      is_rd_q <= 1'b0;
      rx_q    <= 1'b0;
      mdio_o  <= 1'b0;
      mdio_oe <= 1'b0;
    end else if (start) begin
      frame_q <= load_word;
      is_rd_q <= (load_word[OP_HI:OP_LO] == OP_READ);
      mdio_o  <= 1'b1;
      mdio_oe <= 1'b1;
    end else if (abort) begin
      mdio_o  <= 1'b0;
      mdio_oe <= 1'b0;
    end else begin
      if (rise && in_rx) begin
        rx_q <= mdio_i;
      end
      if (fall) begin
        if (bit_idx >= FIRST_FRM) begin
          frame_q <= {frame_q[FRAME_W-2:0], shift_in};
        end
        if (bit_idx == LAST) begin
          mdio_o  <= 1'b0;
          mdio_oe <= 1'b0;
        end else if (nxt_idx == FIRST_FRM) begin
          mdio_o  <= frame_q[FRAME_W-1];
          mdio_oe <= 1'b1;
        end else if (nxt_idx > FIRST_FRM) begin
          mdio_o  <= frame_q[FRAME_W-2];
          mdio_oe <= !(is_rd_q && (nxt_idx >= TA_FROM));
        end else begin
          mdio_o  <= 1'b1;
          mdio_oe <= 1'b1;
        end
      end
    end
  end
endmodule

// File: rtl/mdio_frame_master.sv
module mdio_frame_master
  import mdio_pkg::*;
#(
  parameter int FRAME_W = 32,
  parameter int DATA_W  = 16,
  parameter int PRE_LEN = 32,
  parameter int TA_OFS  = 14
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               port_en,
  input  logic [2:0]         div_sel,
  input  logic               frame_wr,
  input  logic [FRAME_W-1:0] frame_wdata,
  output logic [FRAME_W-1:0] frame_rdata,
  output logic               idle,
  output logic               mdc,
  output logic               mdio_o,
  output logic               mdio_oe,
  input  logic               mdio_i
);
  localparam int TOTAL = PRE_LEN + FRAME_W;
  localparam int CNT_W = $clog2(TOTAL);

  logic             busy;
  logic             accept;
  logic             run;
  logic             abort;
  logic             rise;
  logic             fall;
  logic [CNT_W-1:0] bit_idx;

  assign accept = frame_wr && port_en && !busy;
  assign run    = busy && port_en;
  assign abort  = busy && !port_en;
  assign idle   = !busy;

  mdio_mdc_gen #(.HALF_W(HALF_W)) u_clk (
    .clk     (clk),
    .rst     (rst),
    .start   (accept),
    .run     (run),
    .half_in (half_period(div_sel)),
    .mdc     (mdc),
    .rise    (rise),
    .fall    (fall)
  );

  mdio_bit_seq #(.TOTAL(TOTAL), .CNT_W(CNT_W)) u_seq (
    .clk     (clk),
    .rst     (rst),
    .start   (accept),
    .abort   (abort),
    .fall    (fall),
    .busy    (busy),
    .bit_idx (bit_idx)
  );

  mdio_shift_unit #(
    .FRAME_W (FRAME_W),
    .DATA_W  (DATA_W),
    .PRE_LEN (PRE_LEN),
    .TA_OFS  (TA_OFS),
    .CNT_W   (CNT_W)
  ) u_shift (
    .clk       (clk),
    .rst       (rst),
    .start     (accept),
    .abort     (abort),
    .rise      (rise),
    .fall      (fall),
    .bit_idx   (bit_idx),
    .load_word (frame_wdata),
    .mdio_i    (mdio_i),
    .frame_q   (frame_rdata),
    .mdio_o    (mdio_o),
    .mdio_oe   (mdio_oe)
  );
endmodule

// File: rtl/mdio_frame_master_chk.sv
module mdio_frame_master_chk #(
  parameter int FRAME_W = 32
) (
  input logic               clk,
  input logic               rst,
  input logic               port_en,
  input logic               frame_wr,
  input logic [FRAME_W-1:0] frame_rdata,
  input logic               idle,
  input logic               mdc,
  input logic               mdio_o,
  input logic               mdio_oe
);
  assert_start_drives_R2: assert property (@(posedge clk) disable iff (rst)
    (idle && port_en && frame_wr) |=> (!idle && !mdc && mdio_oe && mdio_o));

  assert_quiet_when_idle_R6: assert property (@(posedge clk) disable iff (rst)
    idle |-> (!mdc && !mdio_oe));

  assert_mdc_rises_busy_R3: assert property (@(posedge clk) disable iff (rst)
    $rose(mdc) |-> !idle);

  assert_disabled_write_ignored_R10: assert property (@(posedge clk) disable iff (rst)
    (idle && !port_en) |=> (idle && $stable(frame_rdata)));

  assert_abort_R11: assert property (@(posedge clk) disable iff (rst)
    (!idle && !port_en) |=> (idle && !mdc && !mdio_oe));
endmodule

bind mdio_frame_master mdio_frame_master_chk #(.FRAME_W(FRAME_W)) u_chk (
  .clk         (clk),
  .rst         (rst),
  .port_en     (port_en),
  .frame_wr    (frame_wr),
  .frame_rdata (frame_rdata),
  .idle        (idle),
  .mdc         (mdc),
  .mdio_o      (mdio_o),
  .mdio_oe     (mdio_oe)
);

// File: tb/mdio_frame_master_bench.sv
`timescale 1ns/1ps
module mdio_frame_master_bench;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        port_en = 1'b0;
  logic [2:0]  div_sel = 3'd0;
  logic        frame_wr = 1'b0;
  logic [31:0] frame_wdata = 32'd0;
  logic [31:0] frame_rdata;
  logic        idle, mdc, mdio_o, mdio_oe;
  logic        phy_drv = 1'b1;
  logic        mdio_i;

  int tests = 0;
  int fails = 0;
  bit done  = 1'b0;

  always #2.5 clk = ~clk;

  assign mdio_i = mdio_oe ? mdio_o : phy_drv;

  mdio_frame_master u_mdio_frame_master (
    .clk(clk), .rst(rst), .port_en(port_en), .div_sel(div_sel),
    .frame_wr(frame_wr), .frame_wdata(frame_wdata), .frame_rdata(frame_rdata),
    .idle(idle), .mdc(mdc), .mdio_o(mdio_o), .mdio_oe(mdio_oe), .mdio_i(mdio_i)
  );

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %h expected %h at %0t", req, act, exp, $time);
    end
  endtask

  function automatic int ratio_of(input logic [2:0] s);
    case (s)
      3'd0: return 8;
      3'd1: return 16;
      3'd2: return 32;
      3'd3: return 48;
      3'd4: return 64;
      default: return 96;
    endcase
  endfunction

  function automatic logic [31:0] mk(input logic [1:0] op, input logic [4:0] phy,
                                     input logic [4:0] rg, input logic [15:0] d);
    return {2'b01, op, phy, rg, 2'b10, d};
  endfunction

  // Run one frame against a cycle-exact behavioural timeline.
  task automatic run_frame(input logic [31:0] word, input logic [2:0] sel,
                           input logic [15:0] rd_val, input logic [2:0] sel_mid,
                           input bit busy_wr, input bit late_wr, input string ttag);
    int n, h;
    bit rd;
    logic [31:0] exp_word;
    n  = ratio_of(sel);
    h  = n / 2;
    rd = (word[29:28] == 2'b10);
    exp_word = rd ? {word[31:16], rd_val} : word;
    @(negedge clk);
    div_sel = sel; frame_wdata = word; frame_wr = 1'b1; port_en = 1'b1;
    @(negedge clk);
    frame_wr = 1'b0; div_sel = sel_mid;
    for (int j = 0; j <= 64 * n; j++) begin
      if (j < 64 * n) begin
        int b, f;
        logic e_mdc, e_oe, e_o;
        string dtag;
        b = j / n;
        e_mdc = ((j % n) >= h);
        if (b < 32) begin
          e_oe = 1'b1; e_o = 1'b1; dtag = "R5";
        end else begin
          f = b - 32;
          e_oe = !(rd && f >= 14);
          e_o  = word[31 - f];
          dtag = e_oe ? "R6" : "R7";
        end
        chk({idle, mdc} == {1'b0, e_mdc}, ttag, {30'd0, idle, mdc}, {30'd0, 1'b0, e_mdc});
        chk((mdio_oe == e_oe) && (!e_oe || mdio_o == e_o), dtag,
            {30'd0, mdio_oe, mdio_o}, {30'd0, e_oe, e_o});
        phy_drv = (rd && b >= 48) ? rd_val[63 - b] : 1'b1;
      end else begin
        chk(idle && !mdc && !mdio_oe, "R6", {29'd0, idle, mdc, mdio_oe}, 32'd4);
        chk(frame_rdata == exp_word, rd ? "R8" : "R6", frame_rdata, exp_word);
      end
      if (busy_wr && j == 3 * n) begin frame_wdata = ~word; frame_wr = 1'b1; end
      if (busy_wr && j == 3 * n + 1) frame_wr = 1'b0;
      if (late_wr && j == 64 * n - 1) begin frame_wdata = ~word; frame_wr = 1'b1; end
      if (j == 64 * n) frame_wr = 1'b0;
      @(negedge clk);
    end
    phy_drv = 1'b1;
    if (late_wr) begin
      for (int k = 0; k < 4; k++) begin
        chk(idle && !mdc && frame_rdata == exp_word, "R9", frame_rdata, exp_word);
        @(negedge clk);
      end
    end
  endtask

  initial begin
    #(5.0 * 150000);
    if (!done) begin
      fails++;
      tests++;
      $display("FAIL watchdog: actual hung expected finished");
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    logic [31:0] keep;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R1 reset state
    chk(idle && !mdc && !mdio_oe && !mdio_o, "R1", {28'd0, idle, mdc, mdio_oe, mdio_o}, 32'h8);
    chk(frame_rdata == 32'd0, "R1", frame_rdata, 32'd0);

    // R2/R5/R6 write frame, ratio 8
    run_frame(mk(2'b01, 5'h11, 5'h04, 16'hBEEF), 3'd0, 16'h0, 3'd0, 1'b0, 1'b0, "R2");
    // R7/R8 read frame, ratio 16
    run_frame(mk(2'b10, 5'h03, 5'h1F, 16'h0000), 3'd1, 16'hA5C3, 3'd1, 1'b0, 1'b0, "R3");
    // R3 remaining ratios; R4 div_sel changed mid-frame
    run_frame(mk(2'b01, 5'h1E, 5'h00, 16'h1234), 3'd2, 16'h0, 3'd5, 1'b0, 1'b0, "R4");
    run_frame(mk(2'b10, 5'h00, 5'h01, 16'hFFFF), 3'd3, 16'h5A0F, 3'd0, 1'b0, 1'b0, "R4");
    run_frame(mk(2'b01, 5'h15, 5'h0A, 16'h8001), 3'd4, 16'h0, 3'd4, 1'b0, 1'b0, "R3");
    run_frame(mk(2'b10, 5'h0A, 5'h15, 16'h0000), 3'd5, 16'h0001, 3'd5, 1'b0, 1'b0, "R3");
    run_frame(mk(2'b01, 5'h01, 5'h02, 16'h7FFE), 3'd7, 16'h0, 3'd7, 1'b0, 1'b0, "R3");
    // R9 write while busy, and write in the completing cycle
    run_frame(mk(2'b10, 5'h07, 5'h09, 16'h0000), 3'd0, 16'hC0DE, 3'd0, 1'b1, 1'b1, "R9");

    // R10 write with port disabled
    keep = frame_rdata;
    port_en = 1'b0; frame_wdata = 32'h6DEADBEE; frame_wr = 1'b1;
    @(negedge clk);
    frame_wr = 1'b0;
    for (int k = 0; k < 20; k++) begin
      chk(idle && !mdc && !mdio_oe && frame_rdata == keep, "R10", frame_rdata, keep);
      @(negedge clk);
    end

    // R11 abort mid-frame
    port_en = 1'b1; div_sel = 3'd0; frame_wdata = mk(2'b01, 5'h02, 5'h03, 16'h4444); frame_wr = 1'b1;
    @(negedge clk);
    frame_wr = 1'b0;
    repeat (100) @(negedge clk);
    chk(!idle, "R11", {31'd0, idle}, 32'd0);
    port_en = 1'b0;
    @(negedge clk);
    chk(idle && !mdc && !mdio_oe, "R11", {29'd0, idle, mdc, mdio_oe}, 32'd4);
    @(negedge clk);
    // recovery after abort
    run_frame(mk(2'b10, 5'h1F, 5'h1F, 16'h0000), 3'd1, 16'h9669, 3'd1, 1'b0, 1'b0, "R11");

    done = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule